// File: doc/BRIEF.md
# Auto-Relatching Audio Block DMA

This block streams audio from memory as a chain of 32-byte blocks. Software programs a 32-bit source address and a 16-bit control word. The control word holds an enable flag and a block count. Each pulse on the block-tick input consumes one block. On that tick the block presents the block address, issues a memory read for it, and advances through the buffer. When the buffer runs out, the engine reloads the programmed address and count by itself and raises a one-cycle interrupt request.

The programmed registers are double-buffered against the running transfer. A write made while streaming changes only the programmed values. The transfer picks them up at its next relatch. Because the interrupt marks the start of a buffer rather than its end, the interrupt handler can program the following buffer while the current one plays. When the engine is disabled, each tick still produces a block, but that block is flagged as silence and no memory read is issued.

Top module: `audio_blk_dma`

## Requirements
- R1: Register word addresses are 0 = source high half, 1 = source low half, 2 = control, 3 = remaining blocks. The control word has its block count in bits [14:0] and its enable flag in bit 15. After reset every register reads zero, and control reads back the last value written.
- R2: Bits [4:0] of the source low half are forced to zero on write, so every block address is 32-byte aligned.
- R3: A control write that sets enable while enable is clear loads the current address from the programmed source and loads the remaining count from the written block count. The new count is readable at address 3 on the next cycle.
- R4: An enabled tick outputs, one cycle later, a block pulse carrying the current address with the silence flag low. If the remaining count is nonzero, it is then decremented and the current address advances by 32.
- R5: When an enabled tick leaves the remaining count at zero, the current address and count reload from the programmed registers and an interrupt pulse follows one cycle later. This also happens on every tick when the programmed count is zero.
- R6: The interrupt also pulses IRQ_DELAY cycles after the enabling write. A disabling control write made before then cancels it.
- R7: A control write while enabled changes only the programmed value. The remaining count is untouched until the next relatch, which uses the new count.
- R8: A tick while disabled outputs a block pulse with the silence flag high and address zero. It issues no memory read and leaves the remaining count unchanged.
- R9: A memory read request stays high with a stable address until acknowledged, and drops the cycle after the acknowledge.
- R10: Writes to address 3 are ignored.
- R11: The interrupt is a one-cycle pulse. A delayed start interrupt and a relatch interrupt due on the same edge give exactly one pulse.
- R12: A register write in the same cycle as a tick takes effect after that tick. The tick uses the enable flag, count and source held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data (combinational on reg_addr_i) |
| tick_i | input | 1 | Block tick, one block per pulse |
| blk_valid_o | output | 1 | One-cycle block pulse |
| blk_zero_o | output | 1 | Block is silence |
| blk_addr_o | output | 32 | Address of the emitted block |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_ack_i | input | 1 | Memory read acknowledge |
| irq_o | output | 1 | Interrupt request pulse |

## Verification
Two interrupt causes can land on the same edge: the delayed start interrupt and a relatch. The bench provokes this by enabling with a count of one and ticking exactly IRQ_DELAY cycles later. It then counts irq pulses over a window and expects exactly one. A second collision puts a disabling control write in the same cycle as a tick. The check is that the tick still streams and relatches with the old values.

// File: rtl/adma_pkg.sv
`timescale 1ns/1ps
package adma_pkg;
  localparam int REG_W = 16;
  typedef enum logic [1:0] {
    RA_SRC_HI = 2'd0,
    RA_SRC_LO = 2'd1,
    RA_CTRL   = 2'd2,
    RA_LEFT   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/adma_regs.sv
`timescale 1ns/1ps
module adma_regs import adma_pkg::*; #(
  parameter int OFS_W = 5,
  localparam int ADDR_W = 2 * REG_W,
  localparam int CNT_W  = REG_W - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [CNT_W-1:0]  left_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              en_o,
  output logic              start_o,
  output logic [CNT_W-1:0]  start_cnt_o,
  output logic              stop_o
);
  logic [ADDR_W-1:0] src_q;
  logic [REG_W-1:0]  ctrl_q;
  logic              ctrl_wr;

  assign ctrl_wr     = we_i && (addr_i == RA_CTRL);
  assign start_o     = ctrl_wr && wdata_i[REG_W-1] && !ctrl_q[REG_W-1];
  assign stop_o      = ctrl_wr && !wdata_i[REG_W-1];
  assign start_cnt_o = wdata_i[CNT_W-1:0];
  assign src_o       = src_q;
  assign cnt_o       = ctrl_q[CNT_W-1:0];
  assign en_o        = ctrl_q[REG_W-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      ctrl_q <= '0;
    end else if (we_i) begin
      case (addr_i)
        RA_SRC_HI: src_q[ADDR_W-1:REG_W] <= wdata_i;
        RA_SRC_LO: src_q[REG_W-1:0]      <= {wdata_i[REG_W-1:OFS_W], {OFS_W{1'b0}}};
        RA_CTRL:   ctrl_q                <= wdata_i;
        default:   ; // remaining count is read-only
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      RA_SRC_HI: rdata_o = src_q[ADDR_W-1:REG_W];
      RA_SRC_LO: rdata_o = src_q[REG_W-1:0];
      RA_CTRL:   rdata_o = ctrl_q;
      default:   rdata_o = {1'b0, left_i};
    endcase
  end
endmodule

// File: rtl/adma_seq.sv
`timescale 1ns/1ps
module adma_seq import adma_pkg::*; #(
  parameter int BLK_BYTES = 32,
  parameter int IRQ_DELAY = 8,
  localparam int ADDR_W = 2 * REG_W,
  localparam int CNT_W  = REG_W - 1,
  localparam int DLY_W  = $clog2(IRQ_DELAY + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  start_cnt_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ADDR_W-1:0] cur_o,
  output logic [CNT_W-1:0]  left_o,
  output logic              dly_hit_o,
  output logic              irq_o
);
  logic [ADDR_W-1:0] cur_q, cur_adv;
  logic [CNT_W-1:0]  left_q, left_dec;
  logic [DLY_W-1:0]  dly_q;
  logic              run_tick, relatch;

  assign run_tick  = tick_i && en_i;
  assign left_dec  = (left_q != '0) ? left_q - 1'b1 : '0;
  assign cur_adv   = (left_q != '0) ? cur_q + ADDR_W'(BLK_BYTES) : cur_q;
  assign relatch   = run_tick && (left_dec == '0);
  assign dly_hit_o = (dly_q == DLY_W'(1));
  assign cur_o     = cur_q;
  assign left_o    = left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      left_q <= '0;
      dly_q  <= '0;
      irq_o  <= 1'b0;
    end else begin
      // start only happens while disabled, so it never meets run_tick
      if (start_i) begin
        cur_q  <= src_i;
        left_q <= start_cnt_i;
      end else if (relatch) begin
        cur_q  <= src_i;
        left_q <= cnt_i;
      end else if (run_tick) begin
        cur_q  <= cur_adv;
        left_q <= left_dec;
      end
      if (start_i)            dly_q <= DLY_W'(IRQ_DELAY);
      else if (stop_i)        dly_q <= '0;
      else if (dly_q != '0)   dly_q <= dly_q - 1'b1;
      irq_o <= relatch || (dly_hit_o && !stop_i);
    end
  end
endmodule

// File: rtl/adma_fetch.sv
`timescale 1ns/1ps
module adma_fetch import adma_pkg::*; #(
  localparam int ADDR_W = 2 * REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic [ADDR_W-1:0] cur_i,
  input  logic              mem_ack_i,
  output logic              blk_valid_o,
  output logic              blk_zero_o,
  output logic [ADDR_W-1:0] blk_addr_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_valid_o <= 1'b0;
      blk_zero_o  <= 1'b0;
      blk_addr_o  <= '0;
      mem_req_o   <= 1'b0;
      mem_addr_o  <= '0;
    end else begin
      blk_valid_o <= tick_i;
      if (tick_i) begin
        blk_zero_o <= !en_i;
        blk_addr_o <= en_i ? cur_i : '0;
      end
      if (tick_i && en_i) begin
        mem_req_o  <= 1'b1;
        mem_addr_o <= cur_i;
      end else if (mem_req_o && mem_ack_i) begin
        mem_req_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_blk_dma.sv
`timescale 1ns/1ps
module audio_blk_dma import adma_pkg::*; #(
  parameter int BLK_BYTES = 32,
  parameter int IRQ_DELAY = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic        tick_i,
  output logic        blk_valid_o,
  output logic        blk_zero_o,
  output logic [31:0] blk_addr_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_ack_i,
  output logic        irq_o
);
  localparam int ADDR_W = 2 * REG_W;
  localparam int CNT_W  = REG_W - 1;
  localparam int OFS_W  = $clog2(BLK_BYTES);

  logic [ADDR_W-1:0] src, cur;
  logic [CNT_W-1:0]  cnt, start_cnt, left_q;
  logic              en, start, stop, dly_hit;

  adma_regs #(.OFS_W(OFS_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .left_i(left_q), .rdata_o(reg_rdata_o),
    .src_o(src), .cnt_o(cnt), .en_o(en),
    .start_o(start), .start_cnt_o(start_cnt), .stop_o(stop)
  );

  adma_seq #(.BLK_BYTES(BLK_BYTES), .IRQ_DELAY(IRQ_DELAY)) u_seq (
    .clk_i, .rst_ni, .tick_i, .en_i(en),
    .start_i(start), .start_cnt_i(start_cnt), .stop_i(stop),
    .src_i(src), .cnt_i(cnt),
    .cur_o(cur), .left_o(left_q), .dly_hit_o(dly_hit), .irq_o
  );

  adma_fetch u_fetch (
    .clk_i, .rst_ni, .tick_i, .en_i(en), .cur_i(cur), .mem_ack_i,
    .blk_valid_o, .blk_zero_o, .blk_addr_o, .mem_req_o, .mem_addr_o
  );
endmodule

// File: rtl/adma_chk.sv
`timescale 1ns/1ps
module adma_chk #(
  parameter int OFS_W = 5,
  parameter int CNT_W = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_addr_i,
  input logic             blk_valid_o,
  input logic             blk_zero_o,
  input logic [31:0]      blk_addr_o,
  input logic             mem_req_o,
  input logic [31:0]      mem_addr_o,
  input logic             mem_ack_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] left_i,
  input logic             dly_hit_i
);
  p_align_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && !blk_zero_o |-> blk_addr_o[OFS_W-1:0] == '0);

  p_zero_blk_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o && blk_zero_o |-> blk_addr_o == '0 && !$rose(mem_req_o));

  p_req_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i |=> mem_req_o);

  p_addr_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i && !tick_i |=> $stable(mem_addr_o));

  p_left_ro_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i && !(reg_we_i && reg_addr_i == 2'd2) |=> $stable(left_i));

  p_irq_cause_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(tick_i) || $past(dly_hit_i));
endmodule

bind audio_blk_dma adma_chk #(.OFS_W(OFS_W), .CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i),
  .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i),
  .blk_valid_o(blk_valid_o), .blk_zero_o(blk_zero_o), .blk_addr_o(blk_addr_o),
  .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
  .irq_o(irq_o), .left_i(left_q), .dly_hit_i(dly_hit)
);

// File: tb/tb_audio_blk_dma.sv
`timescale 1ns/1ps
module tb_audio_blk_dma;
  localparam int D = 8;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0, tick = 1'b0, ack = 1'b0;
  logic [1:0]  ra = 2'd0;
  logic [15:0] wd = 16'd0;
  logic [15:0] rdata;
  logic        bv, bz, req, irq;
  logic [31:0] ba, ma;

  always #10 clk = ~clk;

  audio_blk_dma #(.BLK_BYTES(32), .IRQ_DELAY(D)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(ra), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .tick_i(tick), .blk_valid_o(bv), .blk_zero_o(bz), .blk_addr_o(ba),
    .mem_req_o(req), .mem_addr_o(ma), .mem_ack_i(ack), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0, req_rises = 0;
  logic last_bz = 1'b0;
  logic [31:0] last_ba = '0;
  logic prev_req = 1'b0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model
  logic [31:0] m_src = '0, m_cur = '0, e_ba = '0, e_ma = '0;
  logic [15:0] m_ctrl = '0;
  int          m_left = 0, m_dly = 0;
  bit          e_irq = 0, e_bv = 0, e_bz = 0, e_req = 0;

  always @(posedge clk or negedge rst_n) begin : model
    bit en, st, sp;
    if (!rst_n) begin
      m_src = '0; m_ctrl = '0; m_cur = '0; m_left = 0; m_dly = 0;
      e_irq = 0; e_bv = 0; e_bz = 0; e_ba = '0; e_req = 0; e_ma = '0;
    end else begin
      en = m_ctrl[15];
      st = we && ra == 2'd2 && wd[15] && !en;
      sp = we && ra == 2'd2 && !wd[15];
      e_irq = 0;
      e_bv = tick;
      if (tick) begin
        e_bz = !en;
        e_ba = en ? m_cur : 32'd0;
      end
      if (tick && en) begin
        e_req = 1; e_ma = m_cur;
      end else if (ack && e_req) e_req = 0;
      if (m_dly == 1 && !sp) e_irq = 1;
      if (st) begin
        m_cur = m_src; m_left = int'(wd[14:0]);
      end else if (tick && en) begin
        if (m_left != 0) begin m_left--; m_cur += 32; end
        if (m_left == 0) begin m_cur = m_src; m_left = int'(m_ctrl[14:0]); e_irq = 1; end
      end
      m_dly = st ? D : (sp ? 0 : (m_dly > 0 ? m_dly - 1 : 0));
      if (we) begin
        case (ra)
          2'd0: m_src[31:16] = wd;
          2'd1: m_src[15:0]  = {wd[15:5], 5'b0};
          2'd2: m_ctrl       = wd;
          default: ;
        endcase
      end
    end
  end

  function automatic logic [15:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_src[31:16];
      2'd1: return m_src[15:0];
      2'd2: return m_ctrl;
      default: return 16'(m_left);
    endcase
  endfunction

  // Per-cycle comparison and monitors
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq == e_irq, "R11 irq", 32'(irq), 32'(e_irq));
      chk(bv == e_bv, "R4 blk_valid", 32'(bv), 32'(e_bv));
      if (e_bv) begin
        chk(bz == e_bz, "R8 blk_zero", 32'(bz), 32'(e_bz));
        chk(ba == e_ba, "R4 blk_addr", ba, e_ba);
      end
      chk(req == e_req, "R9 mem_req", 32'(req), 32'(e_req));
      if (e_req) chk(ma == e_ma, "R9 mem_addr", ma, e_ma);
      chk(rdata == exp_rd(ra), "R3 rdata", 32'(rdata), 32'(exp_rd(ra)));
      if (irq) irq_cnt++;
      if (bv) begin last_bz = bz; last_ba = ba; end
      if (req && !prev_req) req_rises++;
      prev_req = req;
    end
  end

  // Memory responder: acknowledge after two waiting cycles
  int wait_c = 0;
  always @(negedge clk) begin
    #1;
    if (req && !ack) begin
      wait_c++;
      if (wait_c >= 2) ack = 1'b1;
    end else begin
      ack = 1'b0; wait_c = 0;
    end
  end

  task automatic step(input bit w, input logic [1:0] a, input logic [15:0] d, input bit t);
    @(negedge clk); #1;
    we = w; ra = a; wd = d; tick = t;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, ra, 16'd0, 0);
  endtask
  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    step(1, a, d, 0);
  endtask
  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    step(0, a, 16'd0, 0); #1 v = rdata;
  endtask
  task automatic tk();
    step(0, ra, 16'd0, 1); idle(5);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    int c0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    rd(2, v); chk(v == 16'h0000, "R1 ctrl reset", 32'(v), 32'h0);
    rd(3, v); chk(v == 16'h0000, "R1 left reset", 32'(v), 32'h0);
    chk(irq == 1'b0, "R1 irq reset", 32'(irq), 32'h0);

    wr(0, 16'h0012); wr(1, 16'h345F);
    rd(1, v); chk(v == 16'h3440, "R2 src lo aligned", 32'(v), 32'h3440);
    rd(0, v); chk(v == 16'h0012, "R1 src hi", 32'(v), 32'h0012);

    tk();
    chk(last_bz == 1'b1, "R8 silent block", 32'(last_bz), 32'h1);
    chk(req_rises == 0, "R8 no fetch", 32'(req_rises), 32'h0);
    rd(3, v); chk(v == 16'd0, "R8 left unchanged", 32'(v), 32'h0);

    c0 = irq_cnt;
    wr(2, 16'h8003);
    rd(3, v); chk(v == 16'd3, "R3 count latched", 32'(v), 32'd3);
    rd(2, v); chk(v == 16'h8003, "R1 ctrl readback", 32'(v), 32'h8003);
    idle(D + 2);
    chk(irq_cnt - c0 == 1, "R6 start irq", 32'(irq_cnt - c0), 32'd1);

    tk();
    chk(last_ba == 32'h0012_3440, "R4 first block", last_ba, 32'h0012_3440);
    rd(3, v); chk(v == 16'd2, "R4 decrement", 32'(v), 32'd2);
    tk();
    chk(last_ba == 32'h0012_3460, "R4 advance 32", last_ba, 32'h0012_3460);
    wr(2, 16'h8002);
    rd(3, v); chk(v == 16'd1, "R7 running untouched", 32'(v), 32'd1);
    c0 = irq_cnt;
    tk();
    chk(last_ba == 32'h0012_3480, "R4 third block", last_ba, 32'h0012_3480);
    chk(irq_cnt - c0 == 1, "R5 relatch irq", 32'(irq_cnt - c0), 32'd1);
    rd(3, v); chk(v == 16'd2, "R7 new count at relatch", 32'(v), 32'd2);
    tk();
    chk(last_ba == 32'h0012_3440, "R5 address reloaded", last_ba, 32'h0012_3440);

    wr(3, 16'h7777);
    rd(3, v); chk(v == 16'd1, "R10 write ignored", 32'(v), 32'd1);

    c0 = irq_cnt;
    step(1, 2, 16'h0002, 1); idle(5);
    chk(last_bz == 1'b0, "R12 tick sees old enable", 32'(last_bz), 32'h0);
    chk(irq_cnt - c0 == 1, "R12 relatch with old values", 32'(irq_cnt - c0), 32'd1);
    rd(3, v); chk(v == 16'd2, "R12 old count reloaded", 32'(v), 32'd2);

    c0 = irq_cnt;
    wr(2, 16'h8001); wr(2, 16'h0001); idle(D + 4);
    chk(irq_cnt - c0 == 0, "R6 cancelled", 32'(irq_cnt - c0), 32'd0);

    c0 = irq_cnt;
    wr(2, 16'h8001);
    idle(D - 1);
    step(0, ra, 16'd0, 1); idle(5);
    chk(irq_cnt - c0 == 1, "R11 merged pulse", 32'(irq_cnt - c0), 32'd1);

    wr(2, 16'h0000); wr(2, 16'h8000); idle(D + 3);
    c0 = irq_cnt;
    tk(); tk();
    chk(irq_cnt - c0 == 2, "R5 zero count every tick", 32'(irq_cnt - c0), 32'd2);
    rd(3, v); chk(v == 16'd0, "R5 zero count", 32'(v), 32'd0);

    idle(3);
    done = 1;
    summary();
    $finish;
  end
endmodule